// File: doc/BRIEF.md
# Grouped Maskable Interrupt Controller

This block collects maskable interrupt sources into groups of four. Each group keeps two control bytes. A status byte holds a pending flag and a detect flag for each of its four sources. A configuration byte holds the enable bit for each source and a 3-bit priority level that the whole group shares. Both bytes are reached through a simple byte-wide register bus. The one register write is also how software acknowledges an interrupt: it rewrites the status byte.

Sources come in as one-cycle fire pulses from a bank of timers, and as four external request lines that the block samples on its clock. When any group holds a set detect flag and the global interrupt enable input is high, the block presents a request. The request carries the level of the lowest-numbered such group. When the CPU answers with a take strobe, the block latches that level into a status-level output. It also loads a group-ID output with the group number shifted left by one. The handler entry address is a constant output. Pushing the stack frame and fetching the vector are left to the CPU.

Top module: `irq_group_ctrl`

## Requirements
- R1: After reset every control byte reads 0x00, no request is presented, and the accepted level and group-ID outputs are 0.
- R2: Group N (numbered from 1) has its status byte at address 2*(N-1) and its configuration byte at address 2*(N-1)+1. A write to the status byte replaces all 8 bits of it, which is how an interrupt is acknowledged.
- R3: In the configuration byte, bits 3:0 are the source enables and bits 6:4 are the group level. Bit 7 is not stored and reads as 0.
- R4: When source s of a group fires, bit 4+s (its pending flag) of that group's status byte is set on the next clock edge, whether or not the source is enabled.
- R5: On any fire in a group, the detect nibble (bits 3:0) ORs in the enable nibble ANDed with the updated pending nibble. This can detect a source that became pending earlier.
- R6: A source that is not enabled never gets its detect bit. Enabling a source that is already pending does not set its detect bit until the next fire in that group.
- R7: Timer n fires source n mod 4 of group n/4+1.
- R8: External lines 0 to 3 fire sources 0 to 3 of group 8. In the default edge mode a line held high fires once, on its rising edge.
- R9: A request is presented only while the global enable input is 1 and some group has a nonzero detect nibble. The presented level is that of the lowest-numbered group with a nonzero detect nibble.
- R10: On a clock edge where take is high while a request is presented, the accepted level takes the presented level and the group-ID output takes the group number shifted left by one. On every other edge both keep their values.
- R11: The handler address output is always 0x080008.
- R12: When a status-byte write and a fire reach the same group in the same cycle, the written value is applied first and the fire is applied on top of it.
- R13: Addresses past the last group read 0x00, and writes to them change no group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address: group index and byte select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| timer_fire | input | NUM_TIMERS | One-cycle fire pulses from the timers |
| ext_irq | input | 4 | External request lines |
| gie | input | 1 | Global interrupt enable |
| irq_take | input | 1 | CPU accepts the presented request |
| irq_req | output | 1 | Request presented to the CPU |
| req_level | output | 3 | Level of the presented group |
| acc_level | output | 3 | Level latched on acceptance |
| acc_gid | output | 8 | Accepted group number shifted left by one |
| handler_addr | output | 24 | Fixed handler entry address |

## Verification
On every cycle the assertions check several properties. Pending and detect flags stay set until a status-byte write. A new detect bit appears only for a source that was enabled. A fire always leaves its pending flag set. A presented request always has a detected group behind it. The accepted level and group ID change only on a take. Only the directed scenarios can show the rest: the timer and external-line mapping onto group and bit, the lowest-group-first ordering, and the case where a source is enabled after it became pending. The same holds for the single fire of a held external line, a write and a fire landing in the same cycle, and out-of-range addresses.

// File: rtl/irqg_pkg.sv
// Package: shared types and constants for the grouped interrupt controller.
// Assumes four sources per group; the byte layouts below are fixed by software.
package irqg_pkg;
    localparam int SRC_PER_GRP = 4;
    localparam int LVL_W       = 3;
    localparam int GID_W       = 8;
    localparam int HADDR_W     = 24;
    localparam logic [HADDR_W-1:0] HANDLER_ENTRY = 24'h080008;

    // Status byte: pending flags in the high nibble, detect flags in the low.
    typedef struct packed {
        logic [SRC_PER_GRP-1:0] pend;
        logic [SRC_PER_GRP-1:0] det;
    } irqg_stat_t;

    // Configuration byte without its unused top bit.
    typedef struct packed {
        logic [LVL_W-1:0]       lvl;
        logic [SRC_PER_GRP-1:0] en;
    } irqg_cfg_t;
endpackage

// File: rtl/irqg_source_map.sv
// Module: routes timer fire pulses and external request lines onto the
// per-group fire nibbles. Timer n goes to group index n/4, bit n%4. The
// external lines go to group number EXT_GROUP. It assumes the timer inputs
// are already single-cycle pulses.
module irqg_source_map
    import irqg_pkg::*;
#(
    parameter int NUM_GROUPS    = 10,
    parameter int NUM_TIMERS    = 10,
    parameter int EXT_GROUP     = 8,
    parameter bit EXT_EDGE_MODE = 1'b1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_TIMERS-1:0]                 timer_fire,
    input  logic [SRC_PER_GRP-1:0]                ext_irq,
    output logic [NUM_GROUPS-1:0][SRC_PER_GRP-1:0] grp_fire
);
    logic [SRC_PER_GRP-1:0] ext_pulse;

    generate
        if (EXT_EDGE_MODE) begin : g_edge
            logic [SRC_PER_GRP-1:0] ext_prev;
            // Remember last sampled line state for rising-edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) ext_prev <= '0;
                else        ext_prev <= ext_irq;
            end
            assign ext_pulse = ext_irq & ~ext_prev;
        end else begin : g_level
            assign ext_pulse = ext_irq;
        end

        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            logic [SRC_PER_GRP-1:0] tmr_bits;
            for (genvar s = 0; s < SRC_PER_GRP; s++) begin : g_src
                if (g * SRC_PER_GRP + s < NUM_TIMERS) begin : g_tmr
                    assign tmr_bits[s] = timer_fire[g * SRC_PER_GRP + s];
                end else begin : g_none
                    assign tmr_bits[s] = 1'b0;
                end
            end
            if (g == EXT_GROUP - 1) begin : g_ext
                assign grp_fire[g] = tmr_bits | ext_pulse;
            end else begin : g_int
                assign grp_fire[g] = tmr_bits;
            end
        end
    endgenerate
endmodule

// File: rtl/irqg_group.sv
// Module: one interrupt group's status and configuration bytes. A status
// write replaces the byte; fires in the same cycle are applied on top of it.
// Detect ORs in enable & pending only in a cycle where the group fires.
module irqg_group
    import irqg_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_stat,
    input  logic                   wr_cfg,
    input  logic [7:0]             wdata,
    input  logic [SRC_PER_GRP-1:0] fire,
    output logic [7:0]             stat_byte,
    output logic [7:0]             cfg_byte,
    output logic                   det_any,
    output logic [LVL_W-1:0]       level
);
    irqg_stat_t stat_q, stat_base, stat_d;
    irqg_cfg_t  cfg_q;

    // Next status: written value (if any), then fire effects on top.
    always_comb begin
        stat_base   = wr_stat ? irqg_stat_t'(wdata) : stat_q;
        stat_d.pend = stat_base.pend | fire;
        stat_d.det  = stat_base.det | ((|fire) ? (cfg_q.en & stat_d.pend) : '0);
    end

    // Status byte register.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    // Configuration byte register; bit 7 is discarded.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (wr_cfg) cfg_q <= irqg_cfg_t'(wdata[6:0]);
    end

    assign stat_byte = stat_q;
    assign cfg_byte  = {1'b0, cfg_q};
    assign det_any   = |stat_q.det;
    assign level     = cfg_q.lvl;

    // Pending flags only clear through a status write (R4).
    assert_pend_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> ((stat_q.pend & $past(stat_q.pend)) == $past(stat_q.pend)));

    // A fire always leaves its pending flag set (R4).
    assert_fire_sets_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|fire) |=> ((stat_q.pend & $past(fire)) == $past(fire)));

    // Detect flags only clear through a status write (R5).
    assert_det_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> ((stat_q.det & $past(stat_q.det)) == $past(stat_q.det)));

    // A newly set detect bit needs its enable (R6).
    assert_det_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> ((stat_q.det & ~$past(stat_q.det) & ~$past(cfg_q.en)) == '0));
endmodule

// File: rtl/irqg_arbiter.sv
// Module: picks the lowest-numbered group with a nonzero detect nibble and
// reports its index and level. Purely combinational.
module irqg_arbiter
    import irqg_pkg::*;
#(
    parameter int NUM_GROUPS = 10,
    parameter int IDX_W      = 4
) (
    input  logic [NUM_GROUPS-1:0]            det_any,
    input  logic [NUM_GROUPS-1:0][LVL_W-1:0] lvl,
    output logic                             found,
    output logic [IDX_W-1:0]                 sel_idx,
    output logic [LVL_W-1:0]                 sel_lvl
);
    // Scan from the top down so the lowest set index wins.
    always_comb begin
        found   = 1'b0;
        sel_idx = '0;
        sel_lvl = '0;
        for (int i = NUM_GROUPS - 1; i >= 0; i--) begin
            if (det_any[i]) begin
                found   = 1'b1;
                sel_idx = IDX_W'(i);
                sel_lvl = lvl[i];
            end
        end
    end
endmodule

// File: rtl/irq_group_ctrl.sv
// Module: grouped maskable interrupt controller top. It decodes the byte
// register bus, instantiates one register pair per group, and arbitrates
// the groups. It also latches the accepted level and group ID on a take.
// Assumes the address holds {group index, byte select} with byte select in bit 0.
module irq_group_ctrl
    import irqg_pkg::*;
#(
    parameter int NUM_GROUPS    = 10,
    parameter int NUM_TIMERS    = 10,
    parameter int EXT_GROUP     = 8,
    parameter bit EXT_EDGE_MODE = 1'b1,
    parameter int ADDR_W        = $clog2(NUM_GROUPS) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [7:0]             reg_wdata,
    output logic [7:0]             reg_rdata,
    input  logic [NUM_TIMERS-1:0]  timer_fire,
    input  logic [SRC_PER_GRP-1:0] ext_irq,
    input  logic                   gie,
    input  logic                   irq_take,
    output logic                   irq_req,
    output logic [LVL_W-1:0]       req_level,
    output logic [LVL_W-1:0]       acc_level,
    output logic [GID_W-1:0]       acc_gid,
    output logic [HADDR_W-1:0]     handler_addr
);
    localparam int IDX_W = ADDR_W - 1;

    logic [IDX_W-1:0]                        acc_idx;
    logic                                    hi_sel;
    logic [NUM_GROUPS-1:0][SRC_PER_GRP-1:0]  grp_fire;
    logic [NUM_GROUPS-1:0][7:0]              stat_bytes, cfg_bytes;
    logic [NUM_GROUPS-1:0]                   grp_det_any;
    logic [NUM_GROUPS-1:0][LVL_W-1:0]        grp_lvl;
    logic                                    found;
    logic [IDX_W-1:0]                        sel_idx;
    logic [LVL_W-1:0]                        sel_lvl;
    logic                                    accept;

    assign acc_idx = reg_addr[ADDR_W-1:1];
    assign hi_sel  = reg_addr[0];

    irqg_source_map #(
        .NUM_GROUPS(NUM_GROUPS), .NUM_TIMERS(NUM_TIMERS),
        .EXT_GROUP(EXT_GROUP), .EXT_EDGE_MODE(EXT_EDGE_MODE)
    ) u_map (
        .clk(clk), .rst_n(rst_n), .timer_fire(timer_fire),
        .ext_irq(ext_irq), .grp_fire(grp_fire)
    );

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            logic hit;
            assign hit = reg_wr && (acc_idx == IDX_W'(g));
            irqg_group u_grp (
                .clk(clk), .rst_n(rst_n),
                .wr_stat(hit && !hi_sel), .wr_cfg(hit && hi_sel),
                .wdata(reg_wdata), .fire(grp_fire[g]),
                .stat_byte(stat_bytes[g]), .cfg_byte(cfg_bytes[g]),
                .det_any(grp_det_any[g]), .level(grp_lvl[g])
            );
        end
    endgenerate

    // Read mux: out-of-range group indices fall through to zero.
    always_comb begin
        reg_rdata = 8'h00;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (acc_idx == IDX_W'(g)) reg_rdata = hi_sel ? cfg_bytes[g] : stat_bytes[g];
        end
    end

    irqg_arbiter #(.NUM_GROUPS(NUM_GROUPS), .IDX_W(IDX_W)) u_arb (
        .det_any(grp_det_any), .lvl(grp_lvl),
        .found(found), .sel_idx(sel_idx), .sel_lvl(sel_lvl)
    );

    assign irq_req      = gie && found;
    assign req_level    = sel_lvl;
    assign accept       = irq_take && irq_req;
    assign handler_addr = HANDLER_ENTRY;

    // Acceptance registers: level stub and group-ID (group number << 1).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_level <= '0;
            acc_gid   <= '0;
        end else if (accept) begin
            acc_level <= sel_lvl;
            acc_gid   <= GID_W'((32'(sel_idx) + 32'd1) << 1);
        end
    end

    // Accepted outputs hold unless a take meets a request (R10).
    assert_acc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(acc_level) && $stable(acc_gid)));

    // Accepted level equals the level that was presented (R10).
    assert_acc_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (acc_level == $past(req_level)));

    // A presented request always has a detected group behind it (R9).
    assert_req_backed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> grp_det_any[sel_idx]);
endmodule

// File: tb/irq_group_ctrl_test.sv
module irq_group_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr;
    logic [4:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [9:0] timer_fire;
    logic [3:0] ext_irq;
    logic       gie, irq_take, irq_req;
    logic [2:0] req_level, acc_level;
    logic [7:0] acc_gid;
    logic [23:0] handler_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_group_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .timer_fire(timer_fire),
        .ext_irq(ext_irq), .gie(gie), .irq_take(irq_take), .irq_req(irq_req),
        .req_level(req_level), .acc_level(acc_level), .acc_gid(acc_gid),
        .handler_addr(handler_addr)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Byte address of group number n (from 1); hi selects the config byte.
    function automatic logic [4:0] ga(input int n, input bit hi);
        return 5'((n - 1) * 2 + int'(hi));
    endfunction

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic fire_tmr(input logic [9:0] mask);
        timer_fire = mask;
        @(negedge clk);
        timer_fire = '0;
    endtask

    task automatic take();
        irq_take = 1'b1;
        @(negedge clk);
        irq_take = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 0; a < 20; a++) begin
            rd(5'(a), d);
            chk("R1 control byte after reset", d, 8'h00);
        end
        chk("R1 irq_req after reset", irq_req, 1'b0);
        chk("R1 acc_level after reset", acc_level, 3'd0);
        chk("R1 acc_gid after reset", acc_gid, 8'd0);
        chk("R11 handler address", handler_addr, 24'h080008);
    endtask

    task automatic t_cfg_byte();
        logic [7:0] d;
        wr(ga(2, 1), 8'hFF);
        rd(ga(2, 1), d);
        chk("R3 config bit7 not stored", d, 8'h7F);
        wr(ga(2, 1), 8'h00);
        rd(ga(2, 1), d);
        chk("R3 config cleared", d, 8'h00);
    endtask

    task automatic t_pending_then_enable();
        logic [7:0] d;
        fire_tmr(10'b10_0000_0000);        // timer 9 -> group 3 bit 1
        rd(ga(3, 0), d);
        chk("R4 R7 pending without enable", d, 8'h20);
        chk("R6 no request when disabled", irq_req, 1'b0);
        wr(ga(3, 1), 8'h32);               // level 3, enable bit 1
        rd(ga(3, 0), d);
        chk("R6 late enable does not detect", d, 8'h20);
        fire_tmr(10'b01_0000_0000);        // timer 8 -> group 3 bit 0
        rd(ga(3, 0), d);
        chk("R5 detect on next fire", d, 8'h32);
        chk("R9 request presented", irq_req, 1'b1);
        chk("R9 presented level", req_level, 3'd3);
    endtask

    task automatic t_take_and_ack();
        logic [7:0] d;
        take();
        chk("R10 accepted level", acc_level, 3'd3);
        chk("R10 accepted group id", acc_gid, 8'd6);
        wr(ga(3, 0), 8'h00);
        rd(ga(3, 0), d);
        chk("R2 ack clears status byte", d, 8'h00);
        chk("R2 request gone after ack", irq_req, 1'b0);
        take();
        chk("R10 take without request keeps level", acc_level, 3'd3);
        chk("R10 take without request keeps gid", acc_gid, 8'd6);
    endtask

    task automatic t_gie();
        wr(ga(1, 1), 8'h21);                // group 1 level 2, enable bit 0
        gie = 1'b0;
        fire_tmr(10'b00_0000_0001);         // timer 0 -> group 1 bit 0
        chk("R9 masked by global enable", irq_req, 1'b0);
        take();
        chk("R10 no accept while masked", acc_gid, 8'd6);
        gie = 1'b1;
        #1;
        chk("R9 request after unmask", irq_req, 1'b1);
        chk("R9 level group 1", req_level, 3'd2);
        wr(ga(1, 0), 8'h00);
    endtask

    task automatic t_priority();
        wr(ga(2, 1), 8'h5F);
        wr(ga(3, 1), 8'h72);
        fire_tmr(10'b10_0001_0000);         // timers 9 and 4 together
        chk("R9 lowest group first level", req_level, 3'd5);
        take();
        chk("R10 gid group 2", acc_gid, 8'd4);
        wr(ga(2, 0), 8'h00);
        chk("R9 next group level", req_level, 3'd7);
        take();
        chk("R10 gid group 3", acc_gid, 8'd6);
        chk("R10 level group 3", acc_level, 3'd7);
        wr(ga(3, 0), 8'h00);
    endtask

    task automatic t_external();
        logic [7:0] d;
        wr(ga(8, 1), 8'h4F);
        ext_irq = 4'b0100;
        @(negedge clk);
        rd(ga(8, 0), d);
        chk("R8 external line 2 to group 8", d, 8'h44);
        wr(ga(8, 0), 8'h00);
        repeat (3) @(negedge clk);
        rd(ga(8, 0), d);
        chk("R8 held line fires once", d, 8'h00);
        ext_irq = 4'b0000;
        @(negedge clk);
        ext_irq = 4'b0001;
        @(negedge clk);
        rd(ga(8, 0), d);
        chk("R8 new rising edge line 0", d, 8'h11);
        take();
        chk("R10 gid group 8", acc_gid, 8'd16);
        ext_irq = 4'b0000;
        wr(ga(8, 0), 8'h00);
    endtask

    task automatic t_write_and_fire();
        logic [7:0] d;
        timer_fire = 10'b10_0000_0000;      // group 3 bit 1, enabled
        wr(ga(3, 0), 8'h80);
        timer_fire = '0;
        rd(ga(3, 0), d);
        chk("R12 write then fire on top", d, 8'hA2);
        wr(ga(3, 0), 8'h00);
    endtask

    task automatic t_out_of_range();
        logic [7:0] d;
        wr(5'd20, 8'hFF);
        wr(5'd21, 8'hFF);
        rd(5'd20, d);
        chk("R13 out-of-range status reads 0", d, 8'h00);
        rd(5'd21, d);
        chk("R13 out-of-range config reads 0", d, 8'h00);
        rd(ga(1, 1), d);
        chk("R13 group 1 untouched", d, 8'h21);
        rd(ga(10, 0), d);
        chk("R13 group 10 untouched", d, 8'h00);
    endtask

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        timer_fire = '0; ext_irq = '0; gie = 1'b1; irq_take = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg_byte();
        t_pending_then_enable();
        t_take_and_ack();
        t_gie();
        t_priority();
        t_external();
        t_write_and_fire();
        t_out_of_range();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule